// File: doc/BRIEF.md
# Delayed-Write Buffer Retire Controller

This block sits on the device side of a banked memory whose writes are staged in a one-entry buffer per device before they reach the array. It sees one decoded column command per packet slot, one slot per clock: idle, write, read or an explicit retire marker. Each command carries a device id, a bank and a column. Row activate and precharge events arrive on their own strobes, each addressing one device and bank.

For each device the block holds the bank and column of the last write, but not its row. It decides in which slot that entry is committed to the array and reports the commit together with the row that is open in that bank at that moment. Reads to the same device postpone a due commit. A write that lands on a still-pending entry of the same device destroys the older write and raises an error pulse. A precharge of the buffered bank while the entry waits raises a warning on the commit, because the data then goes to whatever row is activated afterwards.

Top module: `dwb_retire`

## Requirements
- R1: During and directly after reset every output is 0 and no device holds a pending entry.
- R2: A write command (cmd_i = 1) to device d stores its bank and column in that device's entry. When the entry commits, bit d of commit_o is high and slices d of commit_bank_o and commit_col_o carry the stored bank and column. Slice d of a packed output occupies bits d*W to d*W+W-1, where W is the field width.
- R3: A write in slot k with no read to the same device afterwards commits in slot k+T_RTR. Outputs are registered, so the commit pulse is seen during the cycle after that slot's clock edge, and it lasts exactly one cycle.
- R4: Slice d of commit_row_o is the row most recently activated in device d, bank b, as of the commit slot. An activate that occurs after the write but before the commit changes the reported row.
- R5: A read (cmd_i = 2) to device d in a slot where d's entry is due does not commit the entry. Bit d of holdoff_o pulses instead, and the commit happens in the first later slot that is not a read to d.
- R6: Reads to other devices do not delay a device's commit and do not raise its hold-off.
- R7: A write to one device does not delay the due entries of other devices. A held-off entry on another device commits in the slot of that write.
- R8: A write to device d while d's entry is pending and not due in the same slot raises bit d of overwrite_o. The older write is never committed, and the new write commits T_RTR slots after its own slot.
- R9: A write to device d in the slot where d's entry is due commits the old entry and captures the new one, with no overwrite pulse.
- R10: A retire marker (cmd_i = 3) to device d commits a pending entry in that same slot, whatever its age. A retire marker to an idle device causes no commit.
- R11: Bit d of commit_warn_o is high with a commit when device d's buffered bank was precharged after the write and before the commit slot. A precharge of a different bank does not set it.
- R12: With one column command per slot, no more than T_RTR devices hold pending entries at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one column slot per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 2 | Slot command: 0 idle, 1 write, 2 read, 3 retire marker |
| cmd_dev_i | input | DEV_W | Target device of the slot command |
| cmd_bank_i | input | BANK_W | Target bank of the slot command |
| cmd_col_i | input | COL_W | Target column of the slot command |
| act_i | input | 1 | Row activate strobe |
| act_dev_i | input | DEV_W | Device of the activate |
| act_bank_i | input | BANK_W | Bank of the activate |
| act_row_i | input | ROW_W | Row being activated |
| pre_i | input | 1 | Precharge strobe |
| pre_dev_i | input | DEV_W | Device of the precharge |
| pre_bank_i | input | BANK_W | Bank of the precharge |
| commit_o | output | NUM_DEV | Per-device commit pulse |
| commit_bank_o | output | NUM_DEV*BANK_W | Committed bank, one slice per device |
| commit_col_o | output | NUM_DEV*COL_W | Committed column, one slice per device |
| commit_row_o | output | NUM_DEV*ROW_W | Row open at commit time, one slice per device |
| commit_warn_o | output | NUM_DEV | Commit went to a bank precharged since the write |
| overwrite_o | output | NUM_DEV | Pending write lost to a newer write |
| holdoff_o | output | NUM_DEV | Due commit postponed by a read |

## Verification
The hardest state to reach is a held-off entry whose bank is precharged and then opened on a different row before the commit. The stimulus issues a write, lets it become due, and keeps it due with reads to the same device. Precharge and activate strobes are applied in the same slots as those reads. The commit then follows on the first idle slot, and the bench checks that it reports the new row with the warning set. The same read-hold pattern is swept over hold lengths, and it is also broken by a write to another device, to show when a held entry commits.

// File: rtl/dwb_pkg.sv
package dwb_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_WR  = 2'd1,
    CMD_RD  = 2'd2,
    CMD_RET = 2'd3
  } col_cmd_e;
endpackage

// File: rtl/wbuf_row_table.sv
module wbuf_row_table #(
  parameter int NUM_DEV  = 4,
  parameter int NUM_BANK = 4,
  parameter int ROW_W    = 8,
  localparam int DEV_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  localparam int BANK_W  = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        act_i,
  input  logic [DEV_W-1:0]            act_dev_i,
  input  logic [BANK_W-1:0]           act_bank_i,
  input  logic [ROW_W-1:0]            act_row_i,
  input  logic [NUM_DEV*BANK_W-1:0]   rd_bank_i,
  output logic [NUM_DEV*ROW_W-1:0]    rd_row_o
);
  logic [ROW_W-1:0] row_q [NUM_DEV][NUM_BANK];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int d = 0; d < NUM_DEV; d++)
        for (int b = 0; b < NUM_BANK; b++)
          row_q[d][b] <= '0;
    end else if (act_i) begin
      row_q[act_dev_i][act_bank_i] <= act_row_i;
    end
  end

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_rd
    assign rd_row_o[d*ROW_W +: ROW_W] = row_q[d][rd_bank_i[d*BANK_W +: BANK_W]];
  end
endmodule

// File: rtl/wbuf_entry.sv
module wbuf_entry #(
  parameter int NUM_BANK = 4,
  parameter int COL_W    = 6,
  parameter int T_RTR    = 2,
  localparam int BANK_W  = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1,
  localparam int AGE_W   = $clog2(T_RTR + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              ret_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              pre_i,
  input  logic [BANK_W-1:0] pre_bank_i,
  output logic              pend_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [COL_W-1:0]  col_o,
  output logic              retire_o,
  output logic              overwrite_o,
  output logic              holdoff_o,
  output logic              warn_o
);
  localparam logic [AGE_W-1:0] AGE_DUE = AGE_W'(T_RTR);

  logic              pend_q, warn_q;
  logic [AGE_W-1:0]  age_q;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  col_q;
  logic              due;

  assign due         = pend_q && (age_q >= AGE_DUE);
  // explicit marker wins over age; reads only block an aged entry
  assign retire_o    = pend_q && (ret_i || (due && !rd_i));
  assign holdoff_o   = due && rd_i;
  assign overwrite_o = wr_i && pend_q && !retire_o;
  assign pend_o      = pend_q;
  assign bank_o      = bank_q;
  assign col_o       = col_q;
  assign warn_o      = warn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      warn_q <= 1'b0;
      age_q  <= '0;
      bank_q <= '0;
      col_q  <= '0;
    end else if (wr_i) begin
      pend_q <= 1'b1;
      warn_q <= 1'b0;
      age_q  <= AGE_W'(1);
      bank_q <= bank_i;
      col_q  <= col_i;
    end else if (retire_o) begin
      pend_q <= 1'b0;
      warn_q <= 1'b0;
      age_q  <= '0;
    end else if (pend_q) begin
      if (age_q < AGE_DUE) age_q <= age_q + AGE_W'(1);
      if (pre_i && pre_bank_i == bank_q) warn_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dwb_retire.sv
module dwb_retire #(
  parameter int NUM_DEV  = 4,
  parameter int NUM_BANK = 4,
  parameter int COL_W    = 6,
  parameter int ROW_W    = 8,
  parameter int T_RTR    = 2,
  localparam int DEV_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  localparam int BANK_W  = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [1:0]                cmd_i,
  input  logic [DEV_W-1:0]          cmd_dev_i,
  input  logic [BANK_W-1:0]         cmd_bank_i,
  input  logic [COL_W-1:0]          cmd_col_i,
  input  logic                      act_i,
  input  logic [DEV_W-1:0]          act_dev_i,
  input  logic [BANK_W-1:0]         act_bank_i,
  input  logic [ROW_W-1:0]          act_row_i,
  input  logic                      pre_i,
  input  logic [DEV_W-1:0]          pre_dev_i,
  input  logic [BANK_W-1:0]         pre_bank_i,
  output logic [NUM_DEV-1:0]        commit_o,
  output logic [NUM_DEV*BANK_W-1:0] commit_bank_o,
  output logic [NUM_DEV*COL_W-1:0]  commit_col_o,
  output logic [NUM_DEV*ROW_W-1:0]  commit_row_o,
  output logic [NUM_DEV-1:0]        commit_warn_o,
  output logic [NUM_DEV-1:0]        overwrite_o,
  output logic [NUM_DEV-1:0]        holdoff_o
);
  import dwb_pkg::*;

  col_cmd_e                  cmd;
  logic [NUM_DEV-1:0]        pend_q, retire_c, ovw_c, hold_c, warn_c;
  logic [NUM_DEV*BANK_W-1:0] bank_c;
  logic [NUM_DEV*COL_W-1:0]  col_c;
  logic [NUM_DEV*ROW_W-1:0]  row_c;

  assign cmd = col_cmd_e'(cmd_i);

  wbuf_row_table #(
    .NUM_DEV (NUM_DEV),
    .NUM_BANK(NUM_BANK),
    .ROW_W   (ROW_W)
  ) i_rows (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_i     (act_i),
    .act_dev_i (act_dev_i),
    .act_bank_i(act_bank_i),
    .act_row_i (act_row_i),
    .rd_bank_i (bank_c),
    .rd_row_o  (row_c)
  );

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic hit;
    assign hit = (cmd_dev_i == DEV_W'(d));

    wbuf_entry #(
      .NUM_BANK(NUM_BANK),
      .COL_W   (COL_W),
      .T_RTR   (T_RTR)
    ) i_entry (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (hit && cmd == CMD_WR),
      .rd_i       (hit && cmd == CMD_RD),
      .ret_i      (hit && cmd == CMD_RET),
      .bank_i     (cmd_bank_i),
      .col_i      (cmd_col_i),
      .pre_i      (pre_i && pre_dev_i == DEV_W'(d)),
      .pre_bank_i (pre_bank_i),
      .pend_o     (pend_q[d]),
      .bank_o     (bank_c[d*BANK_W +: BANK_W]),
      .col_o      (col_c[d*COL_W +: COL_W]),
      .retire_o   (retire_c[d]),
      .overwrite_o(ovw_c[d]),
      .holdoff_o  (hold_c[d]),
      .warn_o     (warn_c[d])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      commit_o      <= '0;
      commit_bank_o <= '0;
      commit_col_o  <= '0;
      commit_row_o  <= '0;
      commit_warn_o <= '0;
      overwrite_o   <= '0;
      holdoff_o     <= '0;
    end else begin
      commit_o      <= retire_c;
      commit_bank_o <= bank_c;
      commit_col_o  <= col_c;
      commit_row_o  <= row_c;
      commit_warn_o <= warn_c & retire_c;
      overwrite_o   <= ovw_c;
      holdoff_o     <= hold_c;
    end
  end
endmodule

// File: rtl/dwb_retire_chk.sv
module dwb_retire_chk #(
  parameter int NUM_DEV = 4,
  parameter int T_RTR   = 2,
  parameter int DEV_W   = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [1:0]         cmd_i,
  input logic [DEV_W-1:0]   cmd_dev_i,
  input logic [NUM_DEV-1:0] pend_q,
  input logic [NUM_DEV-1:0] commit_o,
  input logic [NUM_DEV-1:0] overwrite_o,
  input logic [NUM_DEV-1:0] holdoff_o
);
  // R12
  max_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(pend_q) <= T_RTR);

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_chk
    // R2
    capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_i == 2'd1 && cmd_dev_i == DEV_W'(d)) |=> pend_q[d]);
    // R3
    commit_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      commit_o[d] |-> $past(pend_q[d]));
    // R5
    holdoff_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      holdoff_o[d] |-> (pend_q[d] && !commit_o[d]));
    // R8
    overwrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      overwrite_o[d] |-> (pend_q[d] && !commit_o[d]));
    // R10
    marker_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_i == 2'd3 && cmd_dev_i == DEV_W'(d) && pend_q[d]) |=> commit_o[d]);
  end
endmodule

bind dwb_retire dwb_retire_chk #(
  .NUM_DEV(NUM_DEV),
  .T_RTR  (T_RTR),
  .DEV_W  (DEV_W)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_i      (cmd_i),
  .cmd_dev_i  (cmd_dev_i),
  .pend_q     (pend_q),
  .commit_o   (commit_o),
  .overwrite_o(overwrite_o),
  .holdoff_o  (holdoff_o)
);

// File: tb/test_dwb_retire.sv
module test_dwb_retire;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 4, NB = 4, CW = 6, RW = 8, T_RTR = 2;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic [1:0]    cmd_i = '0, cmd_dev_i = '0, cmd_bank_i = '0;
  logic [CW-1:0] cmd_col_i = '0;
  logic          act_i = 1'b0, pre_i = 1'b0;
  logic [1:0]    act_dev_i = '0, act_bank_i = '0, pre_dev_i = '0, pre_bank_i = '0;
  logic [RW-1:0] act_row_i = '0;
  logic [ND-1:0]    commit_o, commit_warn_o, overwrite_o, holdoff_o;
  logic [ND*2-1:0]  commit_bank_o;
  logic [ND*CW-1:0] commit_col_o;
  logic [ND*RW-1:0] commit_row_o;

  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dwb_retire #(.NUM_DEV(ND), .NUM_BANK(NB), .COL_W(CW), .ROW_W(RW), .T_RTR(T_RTR)) i_dwb_retire (
    .clk_i, .rst_ni, .cmd_i, .cmd_dev_i, .cmd_bank_i, .cmd_col_i,
    .act_i, .act_dev_i, .act_bank_i, .act_row_i, .pre_i, .pre_dev_i, .pre_bank_i,
    .commit_o, .commit_bank_o, .commit_col_o, .commit_row_o, .commit_warn_o,
    .overwrite_o, .holdoff_o);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // apply one slot; outputs for it are valid on return
  task automatic step(input int c, input int d, input int b, input int col);
    cmd_i = 2'(c); cmd_dev_i = 2'(d); cmd_bank_i = 2'(b); cmd_col_i = CW'(col);
    @(posedge clk_i); #1;
    act_i = 1'b0; pre_i = 1'b0;
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  function automatic int cb(input int d); return int'(commit_bank_o[d*2 +: 2]); endfunction
  function automatic int cc(input int d); return int'(commit_col_o[d*CW +: CW]); endfunction
  function automatic int cr(input int d); return int'(commit_row_o[d*RW +: RW]); endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    // R1 reset state
    chk("R1 commit", int'(commit_o), 0);
    chk("R1 overwrite", int'(overwrite_o), 0);
    chk("R1 holdoff", int'(holdoff_o), 0);
    chk("R1 warn", int'(commit_warn_o), 0);
    rst_ni = 1'b1;
    nop(1);
    chk("R1 idle after reset", int'(commit_o), 0);

    // open a distinct row in every device/bank
    for (int d = 0; d < ND; d++)
      for (int b = 0; b < NB; b++) begin
        act_i = 1'b1; act_dev_i = 2'(d); act_bank_i = 2'(b); act_row_i = RW'(d*16 + b + 1);
        nop(1);
      end

    // R2/R3 sweep over every device and bank
    for (int d = 0; d < ND; d++)
      for (int b = 0; b < NB; b++) begin
        step(1, d, b, d*4 + b + 5);
        chk("R3 no early commit", int'(commit_o), 0);
        for (int i = 1; i < T_RTR; i++) begin
          nop(1);
          chk("R3 no early commit", int'(commit_o), 0);
        end
        nop(1);
        chk("R3 commit slot", int'(commit_o), 1 << d);
        chk("R2 bank", cb(d), b);
        chk("R2 col", cc(d), d*4 + b + 5);
        chk("R4 row", cr(d), d*16 + b + 1);
        chk("R11 no warn", int'(commit_warn_o), 0);
        nop(1);
        chk("R3 single pulse", int'(commit_o), 0);
      end

    // R5 hold-off for several read run lengths
    for (int n = 1; n <= 4; n++) begin
      step(1, 1, 2, 9);
      nop(T_RTR - 1);
      for (int i = 0; i < n; i++) begin
        step(2, 1, 0, 0);
        chk("R5 holdoff pulse", int'(holdoff_o), 2);
        chk("R5 no commit while read", int'(commit_o), 0);
      end
      nop(1);
      chk("R5 commit after reads", int'(commit_o), 2);
      chk("R5 col", cc(1), 9);
      chk("R5 holdoff clear", int'(holdoff_o), 0);
      nop(2);
    end

    // R6 reads to another device
    step(1, 0, 0, 30);
    step(2, 3, 0, 0);
    step(2, 3, 0, 0);
    chk("R6 commit on time", int'(commit_o), 1);
    chk("R6 no holdoff", int'(holdoff_o), 0);
    nop(2);

    // R7 write to other device releases held entry
    step(1, 2, 0, 20);
    nop(T_RTR - 1);
    step(2, 2, 1, 0);
    step(2, 2, 1, 0);
    step(2, 2, 1, 0);
    chk("R7 still held", int'(commit_o), 0);
    step(1, 0, 3, 21);
    chk("R7 commit on other write", int'(commit_o), 4);
    chk("R7 col", cc(2), 20);
    chk("R7 no overwrite", int'(overwrite_o), 0);
    nop(1);
    chk("R7 gap", int'(commit_o), 0);
    nop(1);
    chk("R7 new write commits", int'(commit_o), 1);
    chk("R7 new col", cc(0), 21);
    nop(2);

    // R8 overwrite before due
    step(1, 3, 0, 1);
    step(1, 3, 1, 2);
    chk("R8 overwrite pulse", int'(overwrite_o), 8);
    chk("R8 no commit", int'(commit_o), 0);
    nop(1);
    chk("R8 old write lost", int'(commit_o), 0);
    nop(1);
    chk("R8 new write commits", int'(commit_o), 8);
    chk("R8 bank", cb(3), 1);
    chk("R8 col", cc(3), 2);
    nop(2);

    // R9 write in due slot
    step(1, 1, 1, 3);
    nop(T_RTR - 1);
    step(1, 1, 2, 4);
    chk("R9 old commits", int'(commit_o), 2);
    chk("R9 old col", cc(1), 3);
    chk("R9 no overwrite", int'(overwrite_o), 0);
    nop(1);
    nop(1);
    chk("R9 new commits", int'(commit_o), 2);
    chk("R9 new col", cc(1), 4);
    nop(2);

    // R10 retire marker
    step(3, 2, 0, 0);
    chk("R10 idle marker no commit", int'(commit_o), 0);
    step(1, 2, 3, 7);
    step(3, 2, 0, 0);
    chk("R10 marker commits", int'(commit_o), 4);
    chk("R10 col", cc(2), 7);
    for (int i = 0; i < 3; i++) begin
      nop(1);
      chk("R10 no second commit", int'(commit_o), 0);
    end

    // R4 activate without precharge changes row
    step(1, 1, 0, 13);
    act_i = 1'b1; act_dev_i = 2'd1; act_bank_i = 2'd0; act_row_i = 8'd77;
    nop(1);
    nop(1);
    chk("R4 commit", int'(commit_o), 2);
    chk("R4 new row", cr(1), 77);
    chk("R11 no precharge no warn", int'(commit_warn_o), 0);
    nop(2);

    // R11/R4 held entry, bank precharged and reopened
    step(1, 0, 1, 11);
    pre_i = 1'b1; pre_dev_i = 2'd0; pre_bank_i = 2'd1;
    nop(1);
    act_i = 1'b1; act_dev_i = 2'd0; act_bank_i = 2'd1; act_row_i = 8'd165;
    step(2, 0, 0, 0);
    chk("R5 held during reopen", int'(holdoff_o), 1);
    nop(1);
    chk("R11 commit", int'(commit_o), 1);
    chk("R4 reopened row", cr(0), 165);
    chk("R11 warn", int'(commit_warn_o), 1);
    nop(2);

    // R11 precharge of another bank
    step(1, 0, 2, 12);
    pre_i = 1'b1; pre_dev_i = 2'd0; pre_bank_i = 2'd3;
    nop(1);
    nop(1);
    chk("R11 commit other bank", int'(commit_o), 1);
    chk("R11 other bank no warn", int'(commit_warn_o), 0);
    chk("R4 row kept", cr(0), 3);

    // R12 two pending devices at once, both drain
    step(1, 0, 0, 40);
    step(1, 1, 0, 41);
    step(2, 1, 0, 0);
    chk("R12 first commits", int'(commit_o), 1);
    step(2, 1, 0, 0);
    chk("R12 second held", int'(holdoff_o), 2);
    nop(1);
    chk("R12 second commits", int'(commit_o), 2);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule